// File: doc/BRIEF.md
# Exception Entry Control Unit

This block keeps the exception-related system-control state of a 64-bit RISC core and performs the state changes that happen when the pipeline takes a synchronous exception or an interrupt. The pipeline raises a one-cycle request carrying an exception kind, the PC of the faulting instruction, a flag saying that instruction sits in a branch delay slot, and the faulting virtual address. On the clock edge where the request is high, the unit records the return PC and delay-slot flag, stores the cause code, enters exception level and, for address-related faults, latches the bad address. In the same cycle it presents the vector address the fetch stage must jump to.

The return PC and delay-slot flag are frozen while the core is already at exception level, so a nested fault does not lose the original return point. The vector offset depends on both the exception kind and the current exception level, and the vector base follows a boot-vector bit in the status word. A small software port reads and writes the status word, the cause word, the return PC and the bad-address register. A separate level-clear input lets the return path leave exception level.

Top module: `exc_entry_ctl`

## Requirements
- R1: After reset the status word reads 0x0040_0004 (boot-vector bit 22 and error-level bit 2 set), the cause word, return PC and bad address read 0, and redir_valid is 0.
- R2: An exception taken with exception level (status bit 1) clear stores exc_pc into the return PC and clears cause bit 31 when exc_in_delay is 0. It stores exc_pc minus 4 and sets cause bit 31 when exc_in_delay is 1.
- R3: An exception taken with status bit 1 already set leaves the return PC and cause bit 31 at their previous values.
- R4: Every exception taken sets status bit 1.
- R5: Cause bits 6..2 receive a code chosen by exc_kind. The mapping is 0 interrupt->0x00, 1 TLB modify->0x01, 2 TLB load/fetch->0x02, 3 TLB store->0x03, 4 address error load/fetch->0x04, 5 address error store->0x05, 6 syscall->0x08, 7 breakpoint->0x09, 8 reserved instruction->0x0A, 9 coprocessor unusable->0x0B, 10 overflow->0x0C, 11 trap->0x0D, 12 coprocessor-2->0x12, 13 extended refill load->0x02, 14 extended refill store->0x03. Kind 15 is treated as reserved instruction (0x0A).
- R6: The vector offset is 0x080 when exc_kind is 13 or 14 and status bit 1 is clear. In every other case it is 0x180.
- R7: While exc_req is high, redir_valid is 1 and redir_pc equals the base plus the sign-extended offset. The base is 0xFFFF_FFFF_BFC0_0200 when status bit 22 is 1 and 0xFFFF_FFFF_8000_0000 otherwise. redir_valid is 0 in any cycle without a request.
- R8: Kinds 1, 2, 3, 4, 5, 13 and 14 load exc_bad_addr into the bad-address register. All other kinds leave it unchanged.
- R9: A pulse on exl_clr clears status bit 1 and leaves the other status bits unchanged. If exc_req is high in the same cycle, the exception wins and bit 1 ends set.
- R10: Software writes apply only to writable bits. The writable status bits are 31..28, 22, 15..8 and 4..0 (mask 0xF040_FF1F). The writable cause bits are 29..28, 22 and 15..8 (mask 0x3040_FF00). All other bits read 0 or keep their hardware value. A software write in a cycle with exc_req high is dropped.
- R11: sw_sel selects what sw_rdata shows combinationally: 0 status, 1 cause (both zero-extended to 64 bits), 2 return PC, 3 bad address. Writes with the same selection are stored in full for the return PC and the bad address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_kind | input | 4 | Exception kind (encoding in R5) |
| exc_pc | input | 64 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_bad_addr | input | 64 | Faulting virtual address |
| exl_clr | input | 1 | Leave exception level (return path) |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Software register select |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Software read data |
| redir_valid | output | 1 | Redirect request for the next PC |
| redir_pc | output | 64 | Exception vector address |

## Verification
The hardest situations to reach from the ports are nested entries: an extended-refill fault arriving while exception level is already set, which must fall back to the general offset and leave the saved return PC and delay flag untouched. The stimulus reaches these by preloading the status word through the software port with the exception-level and boot-vector bits in each combination. It also preloads the return PC and bad address with marker values, so any write that should not happen is visible. Collisions between a request and a software write, or between a request and a level clear, are driven in the same cycle as directed cases.

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [XLEN-1:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter logic [11:0] REFILL_OFS = 12'h080,
  parameter logic [11:0] GEN_OFS = 12'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [3:0]      exc_kind,
  input  logic [XLEN-1:0] exc_pc,
  input  logic            exc_in_delay,
  input  logic [XLEN-1:0] exc_bad_addr,
  input  logic            exl_clr,
  input  logic            sw_we,
  input  logic [1:0]      sw_sel,
  input  logic [XLEN-1:0] sw_wdata,
  output logic [XLEN-1:0] sw_rdata,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);
  localparam logic [31:0] STAT_WMASK  = 32'hF040_FF1F;
  localparam logic [31:0] CAUSE_WMASK = 32'h3040_FF00;
  localparam logic [31:0] STAT_RST    = 32'h0040_0004;
  localparam int EXL_BIT = 1;
  localparam int BEV_BIT = 22;
  localparam int BD_BIT  = 31;

  localparam logic [3:0] K_TLB_MOD = 4'd1, K_TLB_LD = 4'd2, K_TLB_ST = 4'd3;
  localparam logic [3:0] K_ADR_LD = 4'd4, K_ADR_ST = 4'd5;
  localparam logic [3:0] K_XREF_LD = 4'd13, K_XREF_ST = 4'd14;

  logic [31:0]     status_q, cause_q;
  logic [XLEN-1:0] epc_q, bva_q;
  logic [4:0]      code;
  logic            is_refill, is_addr, exl;
  logic [11:0]     ofs;

  assign exl       = status_q[EXL_BIT];
  assign is_refill = (exc_kind == K_XREF_LD) || (exc_kind == K_XREF_ST);
  assign is_addr   = is_refill || (exc_kind == K_TLB_MOD) || (exc_kind == K_TLB_LD) ||
                     (exc_kind == K_TLB_ST) || (exc_kind == K_ADR_LD) || (exc_kind == K_ADR_ST);

  always_comb begin
    case (exc_kind)
      4'd0:  code = 5'h00;
      4'd1:  code = 5'h01;
      4'd2:  code = 5'h02;
      4'd3:  code = 5'h03;
      4'd4:  code = 5'h04;
      4'd5:  code = 5'h05;
      4'd6:  code = 5'h08;
      4'd7:  code = 5'h09;
      4'd9:  code = 5'h0B;
      4'd10: code = 5'h0C;
      4'd11: code = 5'h0D;
      4'd12: code = 5'h12;
      4'd13: code = 5'h02;
      4'd14: code = 5'h03;
      default: code = 5'h0A;
    endcase
  end

  assign ofs         = (is_refill && !exl) ? REFILL_OFS : GEN_OFS;
  assign redir_valid = exc_req;
  assign redir_pc    = (status_q[BEV_BIT] ? BOOT_BASE : NORM_BASE) +
                       {{(XLEN-12){ofs[11]}}, ofs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STAT_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      bva_q    <= '0;
    end else if (exc_req) begin
      if (!exl) begin
        epc_q          <= exc_in_delay ? exc_pc - XLEN'(4) : exc_pc;
        cause_q[BD_BIT] <= exc_in_delay;
      end
      cause_q[6:2]       <= code;
      status_q[EXL_BIT]  <= 1'b1;
      if (is_addr) bva_q <= exc_bad_addr;
    end else begin
      if (sw_we) begin
        case (sw_sel)
          2'd0: status_q <= sw_wdata[31:0] & STAT_WMASK;
          2'd1: cause_q  <= (cause_q & ~CAUSE_WMASK) | (sw_wdata[31:0] & CAUSE_WMASK);
          2'd2: epc_q    <= sw_wdata;
          default: bva_q <= sw_wdata;
        endcase
      end
      if (exl_clr) status_q[EXL_BIT] <= 1'b0;
    end
  end

  always_comb begin
    case (sw_sel)
      2'd0: sw_rdata = {{(XLEN-32){1'b0}}, status_q};
      2'd1: sw_rdata = {{(XLEN-32){1'b0}}, cause_q};
      2'd2: sw_rdata = epc_q;
      default: sw_rdata = bva_q;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctl_chk.sv
module exc_entry_ctl_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            exc_in_delay,
  input logic [XLEN-1:0] exc_pc,
  input logic            exl_clr,
  input logic            sw_we,
  input logic [1:0]      sw_sel,
  input logic            redir_valid,
  input logic            redir_b8,
  input logic            status_exl,
  input logic            cause_bd,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] bva_q
);
  a_r4_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> status_exl);

  a_r3_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && status_exl) |=> ($stable(epc_q) && $stable(cause_bd)));

  a_r2_delay_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !status_exl && exc_in_delay) |=> (cause_bd && epc_q == $past(exc_pc) - XLEN'(4)));

  a_r6_nested_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && status_exl) |-> redir_b8);

  a_r8_bva_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !(sw_we && sw_sel == 2'd3)) |=> $stable(bva_q));

  a_r9_exl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_clr && !exc_req) |=> !status_exl);
endmodule

bind exc_entry_ctl exc_entry_ctl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_in_delay(exc_in_delay),
  .exc_pc(exc_pc), .exl_clr(exl_clr), .sw_we(sw_we), .sw_sel(sw_sel),
  .redir_valid(redir_valid), .redir_b8(redir_pc[8]), .status_exl(status_q[1]),
  .cause_bd(cause_q[31]), .epc_q(epc_q), .bva_q(bva_q)
);

// File: tb/exc_entry_ctl_tb.sv
module exc_entry_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_kind = '0;
  logic [63:0] exc_pc = '0;
  logic        exc_in_delay = 1'b0;
  logic [63:0] exc_bad_addr = '0;
  logic        exl_clr = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = '0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] sw_rdata;
  logic        redir_valid;
  logic [63:0] redir_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
    .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .exc_bad_addr(exc_bad_addr),
    .exl_clr(exl_clr), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  typedef struct packed {
    logic [3:0]  kind;
    logic        dly;
    logic        exl;
    logic        bev;
    logic [4:0]  code;
    logic [63:0] redir;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  1'b0, 1'b0, 1'b1, 5'h00, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd1,  1'b1, 1'b0, 1'b0, 5'h01, 64'hFFFF_FFFF_8000_0180},
    '{4'd2,  1'b0, 1'b0, 1'b0, 5'h02, 64'hFFFF_FFFF_8000_0180},
    '{4'd3,  1'b0, 1'b1, 1'b1, 5'h03, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd4,  1'b1, 1'b0, 1'b1, 5'h04, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd5,  1'b0, 1'b0, 1'b0, 5'h05, 64'hFFFF_FFFF_8000_0180},
    '{4'd6,  1'b1, 1'b1, 1'b0, 5'h08, 64'hFFFF_FFFF_8000_0180},
    '{4'd7,  1'b0, 1'b0, 1'b1, 5'h09, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd8,  1'b0, 1'b0, 1'b0, 5'h0A, 64'hFFFF_FFFF_8000_0180},
    '{4'd9,  1'b1, 1'b0, 1'b0, 5'h0B, 64'hFFFF_FFFF_8000_0180},
    '{4'd10, 1'b0, 1'b1, 1'b1, 5'h0C, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd11, 1'b0, 1'b0, 1'b0, 5'h0D, 64'hFFFF_FFFF_8000_0180},
    '{4'd12, 1'b1, 1'b0, 1'b1, 5'h12, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd13, 1'b0, 1'b0, 1'b0, 5'h02, 64'hFFFF_FFFF_8000_0080},
    '{4'd14, 1'b1, 1'b0, 1'b1, 5'h03, 64'hFFFF_FFFF_BFC0_0280},
    '{4'd13, 1'b0, 1'b1, 1'b1, 5'h02, 64'hFFFF_FFFF_BFC0_0380},
    '{4'd14, 1'b1, 1'b1, 1'b0, 5'h03, 64'hFFFF_FFFF_8000_0180},
    '{4'd15, 1'b0, 1'b0, 1'b0, 5'h0A, 64'hFFFF_FFFF_8000_0180}
  };

  localparam logic [63:0] EPC_MARK = 64'h0000_0000_0000_5550;
  localparam logic [63:0] BVA_MARK = 64'h0000_0000_0000_AAAA;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(logic [1:0] sel, logic [63:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_read(logic [1:0] sel, output logic [63:0] d);
    sw_sel = sel;
    #1;
    d = sw_rdata;
  endtask

  task automatic fire(logic [3:0] k, logic [63:0] pc, logic dly, logic [63:0] bad,
                      output logic rv, output logic [63:0] rp);
    @(negedge clk);
    exc_req = 1'b1; exc_kind = k; exc_pc = pc; exc_in_delay = dly; exc_bad_addr = bad;
    #1;
    rv = redir_valid; rp = redir_pc;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  function automatic bit addr_kind(logic [3:0] k);
    return (k >= 4'd1 && k <= 4'd5) || k == 4'd13 || k == 4'd14;
  endfunction

  initial begin
    logic [63:0] rd, rp, pc, bad, exp_epc, exp_bva;
    logic rv, exp_bd;
    logic [4:0] exp_code;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    sw_read(2'd0, rd); check("R1 status", rd, 64'h0040_0004);
    sw_read(2'd1, rd); check("R1 cause", rd, 64'h0);
    sw_read(2'd2, rd); check("R1 epc", rd, 64'h0);
    sw_read(2'd3, rd); check("R1 badaddr", rd, 64'h0);
    check("R1 redir_valid", {63'b0, redir_valid}, 64'h0);

    exp_bd = 1'b0;
    exp_code = 5'h00;
    for (int i = 0; i < NV; i++) begin
      pc  = 64'h0000_0000_1000_0000 + 64'(i * 16);
      bad = 64'h0000_0000_DEAD_0000 + 64'(i);
      sw_write(2'd2, EPC_MARK);
      sw_write(2'd3, BVA_MARK);
      sw_write(2'd0, {41'b0, VEC[i].bev, 20'b0, VEC[i].exl, 1'b0});
      fire(VEC[i].kind, pc, VEC[i].dly, bad, rv, rp);
      check("R7 redir_valid", {63'b0, rv}, 64'h1);
      check("R6 R7 redir_pc", rp, VEC[i].redir);
      check("R7 redir_valid after", {63'b0, redir_valid}, 64'h0);
      if (!VEC[i].exl) begin
        exp_epc = VEC[i].dly ? pc - 64'd4 : pc;
        exp_bd = VEC[i].dly;
      end else begin
        exp_epc = EPC_MARK; // R3
      end
      exp_code = VEC[i].code;
      exp_bva = addr_kind(VEC[i].kind) ? bad : BVA_MARK;
      sw_read(2'd2, rd); check(VEC[i].exl ? "R3 epc frozen" : "R2 epc", rd, exp_epc);
      sw_read(2'd1, rd);
      check(VEC[i].exl ? "R3 bd frozen" : "R2 bd", {63'b0, rd[31]}, {63'b0, exp_bd});
      check("R5 code", {59'b0, rd[6:2]}, {59'b0, exp_code});
      sw_read(2'd0, rd); check("R4 exl", {63'b0, rd[1]}, 64'h1);
      sw_read(2'd3, rd); check("R8 badaddr", rd, exp_bva);
    end

    // R9 exl clear leaves other bits
    sw_write(2'd0, 64'h0040_0013);
    @(negedge clk); exl_clr = 1'b1;
    @(negedge clk); exl_clr = 1'b0;
    sw_read(2'd0, rd); check("R9 exl clear", rd, 64'h0040_0011);
    // R9 exception wins over clear
    @(negedge clk);
    exl_clr = 1'b1; exc_req = 1'b1; exc_kind = 4'd6; exc_pc = 64'h2000; exc_in_delay = 1'b0;
    @(negedge clk);
    exl_clr = 1'b0; exc_req = 1'b0;
    sw_read(2'd0, rd); check("R9 exception beats clear", {63'b0, rd[1]}, 64'h1);
    sw_read(2'd2, rd); check("R2 epc after clear", rd, 64'h2000);
    exp_bd = 1'b0; exp_code = 5'h08;

    // R10 write masks
    sw_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    sw_read(2'd0, rd); check("R10 status mask", rd, 64'hF040_FF1F);
    sw_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    sw_read(2'd1, rd);
    check("R10 cause mask", rd, {32'b0, exp_bd, 31'h3040_FF00 | {24'b0, exp_code, 2'b0}});
    sw_write(2'd1, 64'h0);
    sw_read(2'd1, rd); check("R10 cause hw bits kept", rd, {59'b0, exp_code} << 2);

    // R10 exception drops simultaneous software write
    sw_write(2'd0, 64'h0);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = 2'd2; sw_wdata = 64'h1234;
    exc_req = 1'b1; exc_kind = 4'd0; exc_pc = 64'h3000; exc_in_delay = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; exc_req = 1'b0;
    sw_read(2'd2, rd); check("R10 exception beats sw write", rd, 64'h2FFC);

    // R11 full-width software access
    sw_write(2'd2, 64'h8765_4321_0FED_CBA8);
    sw_write(2'd3, 64'hFEDC_BA98_7654_3210);
    sw_read(2'd2, rd); check("R11 epc rw", rd, 64'h8765_4321_0FED_CBA8);
    sw_read(2'd3, rd); check("R11 badaddr rw", rd, 64'hFEDC_BA98_7654_3210);
    sw_read(2'd0, rd); check("R11 status upper zero", rd >> 32, 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule